// File: doc/BRIEF.md
# Sign-Magnitude Byte Shifter

This block moves the magnitude bytes of a sign-magnitude accumulator, or of the accumulator and its extension register taken together, by a whole number of bytes. Each register word holds a sign bit and five 6-bit bytes. In the pair modes the accumulator supplies the upper five bytes of one ten-byte magnitude, and the extension register supplies the lower five. The sign bits never take part in a shift.

The block has six shift modes. There are left and right shifts of the accumulator alone, left and right shifts of the pair with zero fill, and left and right rotations of the pair. The sequencer pulses `start` with a mode code, a signed byte count and both register words. Two clock edges later the block raises `done` for one cycle, and the new words appear on `a_out` and `x_out`. A negative count or an unused mode code completes in the same way. In that case `err` is raised and the registers come back unchanged.

Top module: `byte_shifter`

## Requirements
- R1: `done` is high for exactly the one cycle that follows the second rising edge after a cycle with `start` high. With one operation in flight, `done` stays low in the cycle after that first edge.
- R2: Bit 30 of each word is the sign. In every completed operation the sign bit of `a_out` equals that of the `a_in` given with `start`, and the same holds for `x_out` and `x_in`.
- R3: Mode 0 shifts the five magnitude bytes of A toward the most significant end by `count` bytes and fills zeros at the least significant end. X is returned unchanged. Bits 29:24 hold the most significant byte and bits 5:0 the least significant byte.
- R4: Mode 1 shifts the bytes of A toward the least significant end and fills zeros at the most significant end. X is returned unchanged.
- R5: Mode 2 shifts the ten-byte value {A bytes, X bytes} toward the most significant end, with zero fill at the least significant end.
- R6: Mode 3 shifts the ten-byte pair value toward the least significant end, with zero fill at the most significant end.
- R7: Mode 4 rotates the pair value toward the most significant end by `count` mod 10 bytes. Bytes that leave the top re-enter at the bottom.
- R8: Mode 5 rotates the pair value toward the least significant end by `count` mod 10 bytes.
- R9: A zero-fill shift by 5 or more bytes in modes 0 and 1 clears all bytes of A. A zero-fill shift by 10 or more bytes in modes 2 and 3 clears all bytes of both registers.
- R10: `count` is 12-bit two's complement. A negative count completes with `err` high, and the outputs equal the input words.
- R11: Mode codes 6 and 7 complete with `err` high and the outputs equal to the input words. `err` is never high without `done`.
- R12: After reset `a_out`, `x_out`, `done` and `err` are all zero.
- R13: Outside a completion cycle, `a_out` and `x_out` hold their last values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation with the present inputs |
| mode | input | 3 | Shift mode code, 0 to 5 valid |
| count | input | 12 | Signed byte count |
| a_in | input | 31 | Accumulator word: sign at bit 30, five bytes below |
| x_in | input | 31 | Extension word, same layout |
| a_out | output | 31 | Accumulator word after the operation |
| x_out | output | 31 | Extension word after the operation |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Operation rejected, qualified by `done` |

## Verification
The checker relates each completion to the inputs sampled two edges earlier. This assumes that `start` is a clean single-cycle pulse and that the inputs are defined from the first sampled edge on. The bench drives every input from the falling edge and holds all of them at zero through reset. It issues each operation alone and waits for its completion before the next one. Between operations it inverts `a_in` and `x_in` with `start` low, so that a leak from input to output would show. Mode, count and operand pattern are swept together. The sweep includes negative counts, counts at and above the saturation points, and the largest positive count.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    SH_LEFT_A  = 3'd0,
    SH_RIGHT_A = 3'd1,
    SH_LEFT_P  = 3'd2,
    SH_RIGHT_P = 3'd3,
    SH_ROT_L   = 3'd4,
    SH_ROT_R   = 3'd5
  } shmode_e;

  localparam logic [MODE_W-1:0] LAST_MODE = 3'd5;

endpackage

// File: rtl/bsh_capture.sv
module bsh_capture #(
  parameter int WORD_W = 31,
  parameter int CNT_W  = 12,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [CNT_W-1:0]  count,
  input  logic [WORD_W-1:0] a_in,
  input  logic [WORD_W-1:0] x_in,
  output logic              cap_vld,
  output logic [MODE_W-1:0] cap_mode,
  output logic [CNT_W-1:0]  cap_cnt,
  output logic [WORD_W-1:0] cap_a,
  output logic [WORD_W-1:0] cap_x
);

  // First of the two edges: operands are frozen here.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld  <= 1'b0;
      cap_mode <= '0;
      cap_cnt  <= '0;
      cap_a    <= '0;
      cap_x    <= '0;
    end else begin
      cap_vld <= start;
      if (start) begin
        cap_mode <= mode;
        cap_cnt  <= count;
        cap_a    <= a_in;
        cap_x    <= x_in;
      end
    end
  end

endmodule

// File: rtl/bsh_core.sv
module bsh_core
  import bsh_pkg::*;
#(
  parameter int BYTE_W = 6,
  parameter int NBYTES = 5,
  parameter int CNT_W  = 12
) (
  input  logic [MODE_W-1:0]        mode,
  input  logic [CNT_W-1:0]         cnt,
  input  logic [NBYTES*BYTE_W:0]   a_w,
  input  logic [NBYTES*BYTE_W:0]   x_w,
  output logic [NBYTES*BYTE_W:0]   a_res,
  output logic [NBYTES*BYTE_W:0]   x_res,
  output logic                     res_err
);

  localparam int MAG_W  = NBYTES * BYTE_W;
  localparam int PAIR_N = 2 * NBYTES;
  localparam int PAIR_W = PAIR_N * BYTE_W;
  localparam int LIX_W  = $clog2(PAIR_N);

  // Zero-fill shift of one register's magnitude; saturates at NBYTES.
  function automatic logic [MAG_W-1:0] fill_one(input logic [MAG_W-1:0] v,
                                                input logic toward_ms,
                                                input int n);
    if (n >= NBYTES) return '0;
    return toward_ms ? (v << (n * BYTE_W)) : (v >> (n * BYTE_W));
  endfunction

  // Zero-fill shift of the joined pair; saturates at PAIR_N.
  function automatic logic [PAIR_W-1:0] fill_pair(input logic [PAIR_W-1:0] v,
                                                  input logic toward_ms,
                                                  input int n);
    if (n >= PAIR_N) return '0;
    return toward_ms ? (v << (n * BYTE_W)) : (v >> (n * BYTE_W));
  endfunction

  // Source lane for an output lane of the rotator (lane 0 = least significant).
  function automatic logic [LIX_W-1:0] lane_pick(input int g, input int off);
    return LIX_W'((g + off) % PAIR_N);
  endfunction

  logic             sign_a, sign_x;
  logic [MAG_W-1:0] mag_a, mag_x;
  logic [PAIR_W-1:0] pair_v;
  logic             cnt_neg, bad_mode;
  int               amt, rot_k, rot_off;

  assign sign_a   = a_w[MAG_W];
  assign sign_x   = x_w[MAG_W];
  assign mag_a    = a_w[MAG_W-1:0];
  assign mag_x    = x_w[MAG_W-1:0];
  assign pair_v   = {mag_a, mag_x};
  assign cnt_neg  = cnt[CNT_W-1];
  assign bad_mode = (mode > LAST_MODE);
  assign amt      = int'(cnt[CNT_W-2:0]);
  assign rot_k    = amt % PAIR_N;
  assign rot_off  = (mode == SH_ROT_L) ? ((PAIR_N - rot_k) % PAIR_N) : rot_k;

  logic [BYTE_W-1:0] src_ln [PAIR_N];
  logic [BYTE_W-1:0] rot_ln [PAIR_N];
  logic [PAIR_W-1:0] rot_v;

  for (genvar g = 0; g < PAIR_N; g++) begin : g_lane
    assign src_ln[g] = pair_v[g*BYTE_W +: BYTE_W];
    assign rot_ln[g] = src_ln[lane_pick(g, rot_off)];
    assign rot_v[g*BYTE_W +: BYTE_W] = rot_ln[g];
  end

  logic [PAIR_W-1:0] pair_res;

  always_comb begin
    a_res    = a_w;
    x_res    = x_w;
    res_err  = 1'b0;
    pair_res = pair_v;
    if (cnt_neg || bad_mode) begin
      res_err = 1'b1;
    end else begin
      case (shmode_e'(mode))
        SH_LEFT_A:  a_res = {sign_a, fill_one(mag_a, 1'b1, amt)};
        SH_RIGHT_A: a_res = {sign_a, fill_one(mag_a, 1'b0, amt)};
        SH_LEFT_P:  pair_res = fill_pair(pair_v, 1'b1, amt);
        SH_RIGHT_P: pair_res = fill_pair(pair_v, 1'b0, amt);
        SH_ROT_L, SH_ROT_R: pair_res = rot_v;
        default: ;
      endcase
      if (mode >= SH_LEFT_P) begin
        a_res = {sign_a, pair_res[PAIR_W-1:MAG_W]};
        x_res = {sign_x, pair_res[MAG_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/byte_shifter.sv
module byte_shifter
  import bsh_pkg::*;
#(
  parameter int BYTE_W = 6,
  parameter int NBYTES = 5,
  parameter int CNT_W  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [MODE_W-1:0]      mode,
  input  logic [CNT_W-1:0]       count,
  input  logic [NBYTES*BYTE_W:0] a_in,
  input  logic [NBYTES*BYTE_W:0] x_in,
  output logic [NBYTES*BYTE_W:0] a_out,
  output logic [NBYTES*BYTE_W:0] x_out,
  output logic                   done,
  output logic                   err
);

  localparam int WORD_W = NBYTES * BYTE_W + 1;

  logic              cap_vld;
  logic [MODE_W-1:0] cap_mode;
  logic [CNT_W-1:0]  cap_cnt;
  logic [WORD_W-1:0] cap_a, cap_x;
  logic [WORD_W-1:0] res_a, res_x;
  logic              res_err;

  bsh_capture #(.WORD_W(WORD_W), .CNT_W(CNT_W), .MODE_W(MODE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .count(count),
    .a_in(a_in), .x_in(x_in), .cap_vld(cap_vld), .cap_mode(cap_mode),
    .cap_cnt(cap_cnt), .cap_a(cap_a), .cap_x(cap_x)
  );

  bsh_core #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .CNT_W(CNT_W)) u_core (
    .mode(cap_mode), .cnt(cap_cnt), .a_w(cap_a), .x_w(cap_x),
    .a_res(res_a), .x_res(res_x), .res_err(res_err)
  );

  // Second edge: results land and the strobe fires.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_out <= '0;
      x_out <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= cap_vld;
      err  <= cap_vld & res_err;
      if (cap_vld) begin
        a_out <= res_a;
        x_out <= res_x;
      end
    end
  end

endmodule

// File: rtl/bsh_checker.sv
module bsh_checker #(
  parameter int BYTE_W = 6,
  parameter int NBYTES = 5,
  parameter int CNT_W  = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [2:0]             mode,
  input logic [CNT_W-1:0]       count,
  input logic [NBYTES*BYTE_W:0] a_in,
  input logic [NBYTES*BYTE_W:0] x_in,
  input logic [NBYTES*BYTE_W:0] a_out,
  input logic [NBYTES*BYTE_W:0] x_out,
  input logic                   done,
  input logic                   err,
  input logic                   cap_vld
);

  localparam int SB = NBYTES * BYTE_W;

  // R1
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cap_vld);

  // R1
  capture_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |=> done);

  // R1
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));

  // R2
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (a_out[SB] == $past(a_in[SB], 2)) && (x_out[SB] == $past(x_in[SB], 2)));

  // R3
  a_only_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ($past(mode, 2) <= 3'd1)) |-> (x_out == $past(x_in, 2)));

  // R10
  neg_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(count[CNT_W-1], 2)) |-> err);

  // R11
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ($past(mode, 2) > 3'd5)) |-> err);

  // R10
  err_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (a_out == $past(a_in, 2)) && (x_out == $past(x_in, 2)));

  // R11
  err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R13
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(a_out) && $stable(x_out));

endmodule

bind byte_shifter bsh_checker #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .CNT_W(CNT_W)) u_bsh_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .count(count),
  .a_in(a_in), .x_in(x_in), .a_out(a_out), .x_out(x_out),
  .done(done), .err(err), .cap_vld(cap_vld)
);

// File: tb/test_byte_shifter.sv
module test_byte_shifter;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;
  localparam int WORD_W     = 31;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [2:0]        mode = '0;
  logic [CNT_W-1:0]  count = '0;
  logic [WORD_W-1:0] a_in = '0, x_in = '0;
  logic [WORD_W-1:0] a_out, x_out;
  logic              done, err;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_shifter i_byte_shifter (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .count(count),
    .a_in(a_in), .x_in(x_in), .a_out(a_out), .x_out(x_out),
    .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [WORD_W-1:0] join_bytes(input logic s, input int b[10], input int base);
    logic [WORD_W-1:0] w;
    w[30] = s;
    for (int i = 0; i < 5; i++) w[29-6*i -: 6] = b[base+i][5:0];
    return w;
  endfunction

  // Byte model: index 0 is the most significant byte of A, index 9 the least of X.
  task automatic model(input int m, input int n, input logic [WORD_W-1:0] a,
                       input logic [WORD_W-1:0] x, output logic [WORD_W-1:0] ea,
                       output logic [WORD_W-1:0] ex, output bit ee);
    int b[10];
    int nb[10];
    int k;
    for (int i = 0; i < 5; i++) begin
      b[i]   = int'(a[29-6*i -: 6]);
      b[5+i] = int'(x[29-6*i -: 6]);
    end
    nb = b;
    ee = (n < 0) || (m > 5);
    k  = (n < 0) ? 0 : n % 10;
    if (!ee) begin
      case (m)
        0: for (int i = 0; i < 5; i++)  nb[i] = (i + n < 5)  ? b[i+n] : 0;
        1: for (int i = 0; i < 5; i++)  nb[i] = (i - n >= 0) ? b[i-n] : 0;
        2: for (int i = 0; i < 10; i++) nb[i] = (i + n < 10) ? b[i+n] : 0;
        3: for (int i = 0; i < 10; i++) nb[i] = (i - n >= 0) ? b[i-n] : 0;
        4: for (int i = 0; i < 10; i++) nb[i] = b[(i + k) % 10];
        default: for (int i = 0; i < 10; i++) nb[i] = b[(i - k + 10) % 10];
      endcase
    end
    ea = join_bytes(a[30], nb, 0);
    ex = join_bytes(x[30], nb, 5);
  endtask

  function automatic string tag_for(input int m, input int n);
    if (n < 0) return "R10";
    if (m > 5) return "R11";
    if ((m <= 1 && n >= 5) || ((m == 2 || m == 3) && n >= 10)) return "R9";
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] pattern(input int p, input bit ext);
    case (p)
      0: return ext ? {1'b0, 6'd6, 6'd7, 6'd8, 6'd9, 6'd10}
                    : {1'b1, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5};
      1: return ext ? {1'b1, 30'h3FFF_FFFF} : {1'b0, 30'h3FFF_FFFF};
      default: return ext ? {1'b1, 6'd5, 6'd60, 6'd0, 6'd17, 6'd33}
                          : {1'b1, 6'd63, 6'd0, 6'd42, 6'd21, 6'd1};
    endcase
  endfunction

  task automatic run_op(input int m, input int n, input logic [WORD_W-1:0] a,
                        input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] ea, ex;
    bit ee;
    string t;
    model(m, n, a, x, ea, ex, ee);
    t = tag_for(m, n);
    @(negedge clk);
    mode = m[2:0]; count = CNT_W'(n); a_in = a; x_in = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R1 early", 64'(done), 64'd0);
    @(negedge clk);
    check(done == 1'b1 && err == ee, "R1/R10/R11 strobe",
          64'({done, err}), 64'({1'b1, ee}));
    check({a_out, x_out} == {ea, ex}, t, 64'({a_out, x_out}), 64'({ea, ex}));
    check(a_out[30] == a[30] && x_out[30] == x[30], "R2",
          64'({a_out[30], x_out[30]}), 64'({a[30], x[30]}));
    a_in = ~a_in; x_in = ~x_in; mode = ~mode; count = ~count;
    @(negedge clk);
    check(done == 1'b0 && {a_out, x_out} == {ea, ex}, "R13",
          64'({a_out, x_out}), 64'({ea, ex}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12
    check(a_out == '0 && x_out == '0 && done == 1'b0 && err == 1'b0, "R12",
          64'({done, err, a_out, x_out}), 64'd0);
    for (int p = 0; p < 3; p++)
      for (int m = 0; m < 8; m++)
        for (int c = -3; c <= 14; c++)
          run_op(m, (c == 14) ? 2047 : c, pattern(p, 1'b0), pattern(p, 1'b1));
    summary();
  end

endmodule